// File: doc/BRIEF.md
# Windowed Watchdog Timer with Exponential Scale

This block supervises software with a watchdog that has a window as well as a timeout. Software picks a timeout through a 3-bit scale field. Each nonzero value doubles the period of the one before it, and zero turns the watchdog off. Software keeps the system alive by raising a kick bit. A kick that comes too soon after the previous restart counts as a fault, just as a kick that never comes does. When the timeout runs out, the block issues a one-cycle reset pulse and returns to the disabled state.

The block protects itself against careless reprogramming. It accepts a new nonzero scale only when the watchdog is off and has stayed off for a minimum hold time. Every other attempt to change the scale is dropped and recorded. All timing comes from an internal two-stage prescaler: the system clock is divided into microsecond ticks, and those are divided into millisecond ticks. A single write port reaches both the control register and a status register whose bits are cleared by writing 1.

Top module: `wdt_windowed`

## Requirements
- R1: After reset, the scale reads 0, all three status bits read 0, and `wdt_reset` and `early_fault` are low.
- R2: While the scale is 0 the count does not run and no reset pulse occurs. Writing scale 0 to an enabled watchdog stops it.
- R3: For scale n from 1 to 7, `wdt_reset` rises exactly BASE_MS·2^(n−1)·US_PER_MS·CLK_PER_US clock cycles after the last restart edge (an enable or a valid kick), and it stays high for exactly one cycle.
- R4: On a timeout the scale returns to 0 and status bit 2 (timeout) is set, both on the same edge as the reset pulse.
- R5: A valid kick restarts the timeout count. A valid kick is a 0-to-1 change of control bit 7, written while the watchdog is enabled, at least WIN_MS ms after the last restart.
- R6: An early kick is a rising kick that arrives less than WIN_MS ms after the last restart. It gives a one-cycle `early_fault` pulse and sets status bit 0, and it does not restart the count.
- R7: Writing bit 7 as 1 again while it is already 1 is not a kick and does not restart the count.
- R8: The watchdog moves from disabled to enabled only when it has been disabled for at least HOLD_US µs. A sooner nonzero write leaves the scale at 0 and sets status bit 1 (rejected).
- R9: While the watchdog is enabled, writing a different nonzero scale is ignored and sets status bit 1.
- R10: Status bits are sticky. A status write (`wr_sel`=1) clears each bit whose `wr_data` bit is 1: bit 0 early, bit 1 rejected, bit 2 timeout.
- R11: A kick written while the watchdog is disabled has no effect: no fault and no status change.
- R12: Enabling restarts the window, so a kick soon after enable is early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | 0 = control register, 1 = status clear |
| wr_data | input | 8 | Control: [2:0] scale, [7] kick. Status: write-1-to-clear mask |
| wdt_reset | output | 1 | One-cycle reset pulse on timeout |
| early_fault | output | 1 | One-cycle pulse on an early kick |
| scale_o | output | 3 | Scale currently in force (0 = disabled) |
| stat_o | output | 3 | Sticky flags: [0] early kick, [1] rejected scale, [2] timeout |

## Verification
A prescaler whose phase is wrong, or a timeout counter that is off by one, moves the reset pulse away from its exact cycle. The bench measures that cycle on the first timeout after every restart. A window counter that is wrong shows up within a few milliseconds of a restart: a kick the bench expects to be accepted raises `early_fault` instead, or an early kick goes unreported. A hold counter or kick edge register left in the wrong state appears on the very next control write, as an unexpected reject flag or as a timeout that arrives one restart early.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef logic [2:0] scale_t;

  // Flag layout: early kick is bit 0, rejected write bit 1, timeout bit 2.
  typedef struct packed {
    logic timeout;
    logic reject;
    logic early;
  } wdt_stat_t;

  localparam int unsigned MAX_SHIFT = 6;

  // Milliseconds before a timeout for a given scale; zero means off.
  function automatic int unsigned period_ms(int unsigned base_ms, scale_t s);
    if (s == 3'd0) return 0;
    return base_ms << (s - 3'd1);
  endfunction

  // A kick counts only on a low-to-high change of the kick bit.
  function automatic logic kick_edge(logic prev, logic now);
    return now & ~prev;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned CLK_PER_US = 100,
  parameter int unsigned US_PER_MS  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic us_tick,
  output logic ms_tick
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int UW = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
  localparam logic [CW-1:0] CLK_LAST = CW'(CLK_PER_US - 1);
  localparam logic [UW-1:0] US_LAST  = UW'(US_PER_MS - 1);

  logic [CW-1:0] clk_cnt;
  logic [UW-1:0] us_cnt;

  assign us_tick = (clk_cnt == CLK_LAST);
  assign ms_tick = us_tick && (us_cnt == US_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      clk_cnt <= '0;
      us_cnt  <= '0;
    end else begin
      clk_cnt <= us_tick ? '0 : clk_cnt + 1'b1;
      if (us_tick) us_cnt <= (us_cnt == US_LAST) ? '0 : us_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned WIN_MS  = 256,
  parameter int unsigned BASE_MS = 2048
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enabled,
  input  logic   restart,
  input  logic   ms_tick,
  input  scale_t scale,
  output logic   window_open,
  output logic   timeout_evt
);
  localparam int unsigned MAX_MS = BASE_MS << MAX_SHIFT;
  localparam int TW = $clog2(MAX_MS + 1);
  localparam int WW = $clog2(WIN_MS + 1);
  localparam logic [WW-1:0] WIN_LIM = WW'(WIN_MS);

  logic [TW-1:0] to_cnt;
  logic [WW-1:0] win_cnt;
  logic [TW-1:0] limit;

  assign limit       = TW'(period_ms(BASE_MS, scale) - 1);
  assign window_open = (win_cnt >= WIN_LIM);
  assign timeout_evt = enabled && ms_tick && (to_cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !enabled) begin
      to_cnt  <= '0;
      win_cnt <= '0;
    end else if (ms_tick) begin
      to_cnt <= to_cnt + 1'b1;
      if (!window_open) win_cnt <= win_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned HOLD_US = 150
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       us_tick,
  input  logic       window_open,
  input  logic       timeout_evt,
  output scale_t     scale_q,
  output logic       enabled,
  output logic       restart,
  output logic       early_kick,
  output logic       scale_accept,
  output logic       scale_reject,
  output logic       dis_evt,
  output logic       wdt_reset,
  output logic       early_fault,
  output wdt_stat_t  stat_q
);
  localparam int HW = $clog2(HOLD_US + 1);
  localparam logic [HW-1:0] HOLD_LIM = HW'(HOLD_US);

  logic          ctl_wr, sts_wr, kick_q, kick_rise, hold_done, valid_kick;
  logic [HW-1:0] hold_cnt;
  scale_t        new_scale;
  wdt_stat_t     clr_mask;
  logic          wr_unused;

  assign wr_unused = ^wr_data[6:3];
  assign ctl_wr    = wr_en && !wr_sel;
  assign sts_wr    = wr_en && wr_sel;
  assign new_scale = wr_data[2:0];
  assign clr_mask  = sts_wr ? wdt_stat_t'(wr_data[2:0]) : '0;
  assign enabled   = (scale_q != 3'd0);
  assign hold_done = (hold_cnt >= HOLD_LIM);
  assign kick_rise = ctl_wr && kick_edge(kick_q, wr_data[7]);

  assign dis_evt      = ctl_wr && enabled && (new_scale == 3'd0) && !timeout_evt;
  assign scale_accept = ctl_wr && !enabled && (new_scale != 3'd0) && hold_done;
  assign scale_reject = ctl_wr && (new_scale != 3'd0) &&
                        ((!enabled && !hold_done) ||
                         (enabled && (new_scale != scale_q) && !timeout_evt));

  assign early_kick = kick_rise && enabled && !timeout_evt && !dis_evt && !window_open;
  assign valid_kick = kick_rise && enabled && !timeout_evt && !dis_evt && window_open;
  assign restart    = scale_accept || valid_kick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale_q     <= '0;
      hold_cnt    <= '0;
      kick_q      <= 1'b0;
      wdt_reset   <= 1'b0;
      early_fault <= 1'b0;
      stat_q      <= '0;
    end else begin
      if (timeout_evt || dis_evt) scale_q <= '0;
      else if (scale_accept)      scale_q <= new_scale;

      if (timeout_evt || dis_evt)              hold_cnt <= '0;
      else if (!enabled && us_tick && !hold_done) hold_cnt <= hold_cnt + 1'b1;

      if (ctl_wr) kick_q <= wr_data[7];

      wdt_reset   <= timeout_evt;
      early_fault <= early_kick;

      stat_q.early   <= early_kick   || (stat_q.early   && !clr_mask.early);
      stat_q.reject  <= scale_reject || (stat_q.reject  && !clr_mask.reject);
      stat_q.timeout <= timeout_evt  || (stat_q.timeout && !clr_mask.timeout);
    end
  end
endmodule

// File: rtl/wdt_windowed.sv
module wdt_windowed
  import wdt_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 100,
  parameter int unsigned US_PER_MS  = 1000,
  parameter int unsigned WIN_MS     = 256,
  parameter int unsigned BASE_MS    = 2048,
  parameter int unsigned HOLD_US    = 150
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       wdt_reset,
  output logic       early_fault,
  output logic [2:0] scale_o,
  output logic [2:0] stat_o
);
  logic      us_tick, ms_tick, restart, enabled, window_open, timeout_evt;
  logic      early_kick, scale_accept, scale_reject, dis_evt;
  scale_t    scale_q;
  wdt_stat_t stat_q;

  wdt_prescaler #(.CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS)) i_presc (
    .clk(clk), .rst_n(rst_n), .clear(restart),
    .us_tick(us_tick), .ms_tick(ms_tick)
  );

  wdt_timer #(.WIN_MS(WIN_MS), .BASE_MS(BASE_MS)) i_timer (
    .clk(clk), .rst_n(rst_n), .enabled(enabled), .restart(restart),
    .ms_tick(ms_tick), .scale(scale_q),
    .window_open(window_open), .timeout_evt(timeout_evt)
  );

  wdt_ctrl #(.HOLD_US(HOLD_US)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .us_tick(us_tick), .window_open(window_open), .timeout_evt(timeout_evt),
    .scale_q(scale_q), .enabled(enabled), .restart(restart),
    .early_kick(early_kick), .scale_accept(scale_accept),
    .scale_reject(scale_reject), .dis_evt(dis_evt),
    .wdt_reset(wdt_reset), .early_fault(early_fault), .stat_q(stat_q)
  );

  assign scale_o = scale_q;
  assign stat_o  = stat_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sts_clr_to,
  input logic       wdt_reset,
  input logic       early_fault,
  input logic [2:0] scale_o,
  input logic [2:0] stat_o,
  input logic       timeout_evt,
  input logic       early_kick,
  input logic       scale_accept,
  input logic       scale_reject,
  input logic       dis_evt
);
  assert_reset_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);

  assert_timeout_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (wdt_reset && scale_o == 3'd0 && stat_o[2]));

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_o == 3'd0) |-> !timeout_evt);

  assert_early_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    early_kick |=> (early_fault && stat_o[0] && scale_o == $past(scale_o)));

  assert_reject_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scale_reject |=> (stat_o[1] && scale_o == $past(scale_o)));

  assert_scale_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_o != $past(scale_o)) |-> $past(scale_accept || timeout_evt || dis_evt));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[2] && !sts_clr_to) |=> stat_o[2]);
endmodule

bind wdt_windowed wdt_checker i_wdt_checker (
  .clk(clk), .rst_n(rst_n),
  .sts_clr_to(wr_en && wr_sel && wr_data[2]),
  .wdt_reset(wdt_reset), .early_fault(early_fault),
  .scale_o(scale_o), .stat_o(stat_o),
  .timeout_evt(timeout_evt), .early_kick(early_kick),
  .scale_accept(scale_accept), .scale_reject(scale_reject), .dis_evt(dis_evt)
);

// File: tb/test_wdt_windowed.sv
module test_wdt_windowed;
  localparam int CPU  = 2;
  localparam int UPM  = 4;
  localparam int WIN  = 3;
  localparam int BASE = 8;
  localparam int HOLD = 6;
  localparam int MS_CYC = CPU * UPM;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic wdt_reset, early_fault;
  logic [2:0] scale_o, stat_o;

  int cyc = 0, checks = 0, fails = 0, n_resets = 0, n_faults = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (wdt_reset) n_resets++;
    if (early_fault) n_faults++;
  end

  wdt_windowed #(.CLK_PER_US(CPU), .US_PER_MS(UPM), .WIN_MS(WIN),
                 .BASE_MS(BASE), .HOLD_US(HOLD)) i_wdt_windowed (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wdt_reset(wdt_reset), .early_fault(early_fault),
    .scale_o(scale_o), .stat_o(stat_o)
  );

  function automatic int exp_cycles(int s);
    int ms = BASE;
    for (int i = 1; i < s; i++) ms = ms * 2;
    return ms * MS_CYC;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d, output int edge_no);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; edge_no = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Returns the cycle count at which wdt_reset is first seen high.
  task automatic wait_reset(input int limit, output int seen);
    seen = -1;
    for (int i = 0; i < limit; i++) begin
      if (wdt_reset) begin seen = cyc; break; end
      @(negedge clk);
    end
  endtask

  int e, k, seen, f0, r0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(scale_o == 0 && stat_o == 0 && !wdt_reset && !early_fault, "R1",
          {scale_o, stat_o}, 0);

    // R8 enable too soon after reset
    wr(1'b0, 8'h01, e);
    check(scale_o == 0, "R8 early enable scale", scale_o, 0);
    check(stat_o == 3'b010, "R8 reject flag", stat_o, 2);
    // R10 write-1-to-clear
    wr(1'b1, 8'h02, e);
    check(stat_o == 0, "R10 clear", stat_o, 0);

    // R11 kick while disabled
    wr(1'b0, 8'h80, e); wr(1'b0, 8'h00, e);
    check(stat_o == 0 && n_faults == 0, "R11 kick disabled", stat_o, 0);

    idle(2 * HOLD * CPU);
    wr(1'b0, 8'h01, e);
    check(scale_o == 1, "R8 enable after hold", scale_o, 1);

    // R12/R6 early kick right after enable, no restart
    wr(1'b0, 8'h81, k);
    check(early_fault == 1 && stat_o[0], "R6 R12 early fault", early_fault, 1);
    wr(1'b0, 8'h01, k);
    wait_reset(5000, seen);
    check(seen - e == exp_cycles(1), "R6 R3 timeout from enable", seen - e, exp_cycles(1));
    check(scale_o == 0 && stat_o[2] == 1, "R4 cleared scale", scale_o, 0);
    @(negedge clk);
    check(!wdt_reset, "R3 single cycle pulse", wdt_reset, 0);
    check(stat_o == 3'b101, "R10 sticky flags", stat_o, 5);
    wr(1'b1, 8'h07, k);
    check(stat_o == 0, "R10 clear all", stat_o, 0);

    // R2 disable stops the count
    idle(2 * HOLD * CPU);
    wr(1'b0, 8'h02, e);
    idle(40);
    r0 = n_resets;
    wr(1'b0, 8'h00, e);
    idle(3 * exp_cycles(2));
    check(scale_o == 0 && n_resets == r0, "R2 disabled no reset", n_resets - r0, 0);

    // R9 scale change while enabled
    wr(1'b0, 8'h02, e);
    wr(1'b0, 8'h03, k);
    check(scale_o == 2 && stat_o[1], "R9 change ignored", scale_o, 2);
    wr(1'b0, 8'h00, k);
    wr(1'b1, 8'h07, k);

    // R5/R7 valid kick restarts, held bit does not
    idle(2 * HOLD * CPU);
    f0 = n_faults;
    wr(1'b0, 8'h01, e);
    idle(WIN * MS_CYC + 6);
    wr(1'b0, 8'h81, k);
    idle(20);
    wr(1'b0, 8'h81, e);
    wait_reset(5000, seen);
    check(seen - k == exp_cycles(1), "R5 R7 timeout from first kick", seen - k, exp_cycles(1));
    check(n_faults == f0, "R5 no fault on valid kick", n_faults - f0, 0);
    wr(1'b0, 8'h00, e);

    // R3 largest scale
    idle(2 * HOLD * CPU);
    wr(1'b0, 8'h07, e);
    wait_reset(10000, seen);
    check(seen - e == exp_cycles(7), "R3 scale 7", seen - e, exp_cycles(7));

    // R3/R5 random restarts
    void'($urandom(32'd1234));
    for (int it = 0; it < 8; it++) begin
      int s, nk, last;
      s = 1 + ($urandom % 3);
      nk = $urandom % 4;
      idle(2 * HOLD * CPU);
      wr(1'b0, 8'(s), last);
      for (int j = 0; j < nk; j++) begin
        int d;
        d = 30 + ($urandom % (exp_cycles(s) - 44));
        idle(d - 2);
        wr(1'b0, 8'h80 | 8'(s), last);
        wr(1'b0, 8'(s), e);
      end
      wait_reset(5000, seen);
      check(seen - last == exp_cycles(s), "R3 R5 random timeout", seen - last, exp_cycles(s));
    end
    check(stat_o[0] == 0, "R5 random kicks all valid", stat_o[0], 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule